// File: doc/BRIEF.md
# Fixed-Point Leaky Integrate-and-Fire Neuron

This block models one spiking neuron with a single membrane variable held in signed Q8.8 (16 bits, 8 of them fractional; a real value v is stored as round(v·256)). Each cycle with the step enable high, it takes one forward-Euler step toward the resting potential, driven by a signed input current. The division by the membrane time constant becomes an arithmetic right shift by ceil(log2 tau). The sum is formed at a width widened by guard bits, then clamped back to 16 bits.

When the freshly clamped value lies strictly above the firing threshold, the membrane is loaded with the reset potential and a one-cycle spike pulse is issued. The resting potential, reset potential, threshold and time constant are parameters. By default they are −65, −65, −50 and 10, which gives a shift of 4. A host steps the neuron at its own rate and watches the spike line.

Top module: `lif_neuron_q`

## Requirements
- R1: While rst_n is low and after it is released, mem_v reads the reset potential (default −16640, i.e. −65.0) and spike is 0.
- R2: In a cycle with step_en low, mem_v keeps its value and spike is 0 at the next edge.
- R3: With step_en high, the candidate is v + floor((I − (v − V_REST)) / 2^S), where S = ceil(log2 TAU) (4 for TAU = 10) and all values are Q8.8 integers.
- R4: The candidate is computed at W + G bits, G = ceil(log2 N_ADD) with N_ADD = 3, so extreme v and I combinations give the exact mathematical result before clamping.
- R5: A candidate above 32767 is stored as 32767 and never wraps to a negative value.
- R6: A candidate below −32768 is stored as −32768 and never wraps to a positive value.
- R7: A spike fires only when the clamped candidate is strictly greater than V_THRESH (default −12800, i.e. −50.0). A candidate equal to the threshold is stored and does not fire.
- R8: On a firing step, mem_v shows the reset potential in the same cycle that spike is 1. The spike lasts one cycle unless the following step fires again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| step_en | input | 1 | Advances the membrane by one Euler step |
| i_cur | input | 16 | Signed Q8.8 input current |
| mem_v | output | 16 | Signed Q8.8 membrane value |
| spike | output | 1 | One-cycle firing pulse |

## Verification
The membrane register drives mem_v directly. A wrong update, a missing clamp or a wrapped intermediate therefore shows at the port on the edge of the same step, and a single-step comparison against an integer model exposes it. A wrong threshold decision shows at once as a spike or a missing spike, and as a non-reset mem_v in that same cycle. The bench drives the membrane to exactly the threshold and one LSB above it, and pins both clamp limits using a second instance whose parameters can reach the upper rail.

// File: rtl/lif_pkg.sv
`timescale 1ns/1ps
package lif_pkg;
  localparam int Q_W    = 16;
  localparam int Q_FRAC = 8;

  // whole-number potential to Q8.8 integer
  function automatic int q_of_int(input int whole);
    return whole * (1 << Q_FRAC);
  endfunction

  // bits needed to absorb n chained additions
  function automatic int guard_bits(input int n_add);
    return (n_add <= 1) ? 1 : $clog2(n_add);
  endfunction
endpackage

// File: rtl/lif_euler_step.sv
`timescale 1ns/1ps
module lif_euler_step #(
  parameter int W      = 16,
  parameter int WG     = 18,
  parameter int SHIFT  = 4,
  parameter int V_REST = -16640
) (
  input  logic signed [W-1:0]  v_cur,
  input  logic signed [W-1:0]  i_in,
  output logic signed [WG-1:0] v_wide
);
  localparam int EXT = WG - W;
  localparam logic signed [WG-1:0] REST_W = WG'(V_REST);

  logic signed [WG-1:0] v_x;
  logic signed [WG-1:0] i_x;
  logic signed [WG-1:0] offset;
  logic signed [WG-1:0] drive;
  logic signed [WG-1:0] leak;

  always_comb begin
    v_x    = {{EXT{v_cur[W-1]}}, v_cur};
    i_x    = {{EXT{i_in[W-1]}}, i_in};
    offset = v_x - REST_W;
    drive  = i_x - offset;
    leak   = drive >>> SHIFT;
    v_wide = v_x + leak;
  end
endmodule

// File: rtl/lif_saturate.sv
`timescale 1ns/1ps
module lif_saturate #(
  parameter int WI = 18,
  parameter int WO = 16
) (
  input  logic signed [WI-1:0] d_in,
  output logic signed [WO-1:0] d_out
);
  localparam logic signed [WO-1:0] POS_RAIL = {1'b0, {(WO-1){1'b1}}};
  localparam logic signed [WO-1:0] NEG_RAIL = {1'b1, {(WO-1){1'b0}}};

  generate
    if (WI > WO) begin : g_clamp
      logic [WI-WO:0] hi_bits;
      logic           fits;
      always_comb begin
        hi_bits = d_in[WI-1:WO-1];
        fits    = (&hi_bits) | ~(|hi_bits);
        if (fits)
          d_out = d_in[WO-1:0];
        else if (d_in[WI-1])
          d_out = NEG_RAIL;
        else
          d_out = POS_RAIL;
      end
    end else begin : g_pass
      assign d_out = d_in[WO-1:0];
    end
  endgenerate
endmodule

// File: rtl/lif_fire.sv
`timescale 1ns/1ps
module lif_fire #(
  parameter int W        = 16,
  parameter int V_THRESH = -12800,
  parameter int V_RESET  = -16640
) (
  input  logic signed [W-1:0] v_cand,
  output logic                fire,
  output logic signed [W-1:0] v_load
);
  localparam logic signed [W-1:0] TH_Q  = W'(V_THRESH);
  localparam logic signed [W-1:0] RST_Q = W'(V_RESET);

  always_comb begin
    fire   = (v_cand > TH_Q);
    v_load = fire ? RST_Q : v_cand;
  end
endmodule

// File: rtl/lif_neuron_q.sv
`timescale 1ns/1ps
module lif_neuron_q #(
  parameter int W        = lif_pkg::Q_W,
  parameter int TAU      = 10,
  parameter int N_ADD    = 3,
  parameter int V_REST   = lif_pkg::q_of_int(-65),
  parameter int V_RESET  = lif_pkg::q_of_int(-65),
  parameter int V_THRESH = lif_pkg::q_of_int(-50)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_en,
  input  logic signed [W-1:0] i_cur,
  output logic signed [W-1:0] mem_v,
  output logic                spike
);
  localparam int SHIFT = $clog2(TAU);
  localparam int G     = lif_pkg::guard_bits(N_ADD);
  localparam int WG    = W + G;
  localparam logic signed [W-1:0] RST_Q = W'(V_RESET);

  logic signed [W-1:0]  v_q;
  logic signed [W-1:0]  v_d;
  logic                 spk_q;
  logic                 spk_d;
  logic signed [WG-1:0] v_wide;
  logic signed [W-1:0]  v_sat;
  logic                 fire;
  logic signed [W-1:0]  v_load;

  lif_euler_step #(
    .W(W), .WG(WG), .SHIFT(SHIFT), .V_REST(V_REST)
  ) u_step (
    .v_cur(v_q), .i_in(i_cur), .v_wide(v_wide)
  );

  lif_saturate #(
    .WI(WG), .WO(W)
  ) u_sat (
    .d_in(v_wide), .d_out(v_sat)
  );

  lif_fire #(
    .W(W), .V_THRESH(V_THRESH), .V_RESET(V_RESET)
  ) u_fire (
    .v_cand(v_sat), .fire(fire), .v_load(v_load)
  );

  // next-state selection
  always_comb begin
    v_d   = v_q;
    spk_d = 1'b0;
    if (step_en) begin
      v_d   = v_load;
      spk_d = fire;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= RST_Q;
      spk_q <= 1'b0;
    end else begin
      v_q   <= v_d;
      spk_q <= spk_d;
    end
  end

  assign mem_v = v_q;
  assign spike = spk_q;
endmodule

// File: rtl/lif_chk.sv
`timescale 1ns/1ps
module lif_chk #(
  parameter int W       = 16,
  parameter int V_RESET = -16640
) (
  input logic                clk,
  input logic                rst_n,
  input logic                step_en,
  input logic signed [W-1:0] mem_v,
  input logic                spike
);
  localparam logic signed [W-1:0] RST_Q = W'(V_RESET);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(mem_v) && !spike));

  // R2
  move_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_v) |-> $past(step_en));

  // R8
  spike_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spike |-> (mem_v == RST_Q));

  // R7
  spike_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spike) |-> $past(step_en));
endmodule

bind lif_neuron_q lif_chk #(.W(W), .V_RESET(V_RESET)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_en(step_en), .mem_v(mem_v), .spike(spike)
);

// File: tb/sim_lif_neuron_q.sv
`timescale 1ns/1ps
module sim_lif_neuron_q;
  localparam int REST  = -16640;
  localparam int RSTV  = -16640;
  localparam int THR   = -12800;
  localparam int SH    = 4;
  localparam int REST1 = 16000;
  localparam int THR1  = 32767;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_en = 1'b0;
  logic signed [15:0] i_cur = '0;
  logic signed [15:0] mem_v;
  logic spike;
  logic step_en1 = 1'b0;
  logic signed [15:0] i_cur1 = '0;
  logic signed [15:0] mem_v1;
  logic spike1;

  int n_chk = 0;
  int n_err = 0;
  int gv = RSTV;
  int gv1 = RSTV;
  bit done = 0;

  always #2 clk = ~clk;

  lif_neuron_q u0 (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .i_cur(i_cur),
    .mem_v(mem_v), .spike(spike)
  );

  lif_neuron_q #(.V_REST(REST1), .V_THRESH(THR1)) u1 (
    .clk(clk), .rst_n(rst_n), .step_en(step_en1), .i_cur(i_cur1),
    .mem_v(mem_v1), .spike(spike1)
  );

  function automatic int g_next(input int v, input int cur, input int rest);
    int d;
    int n;
    d = cur - (v - rest);
    n = v + (d >>> SH);
    if (n > 32767) n = 32767;
    if (n < -32768) n = -32768;
    return n;
  endfunction

  task automatic check(input string req, input int act_v, input int act_s,
                       input int exp_v, input int exp_s);
    n_chk++;
    if (act_v != exp_v || act_s != exp_s) begin
      n_err++;
      $display("FAIL %s: mem=%0d spike=%0d expected mem=%0d spike=%0d",
               req, act_v, act_s, exp_v, exp_s);
    end
  endtask

  // one step of u0, returns whether the model fired
  task automatic step0(input int cur, input string req, output bit fired);
    int n;
    @(negedge clk);
    step_en = 1'b1;
    i_cur = 16'(cur);
    @(posedge clk);
    #1;
    step_en = 1'b0;
    n = g_next(gv, cur, REST);
    fired = (n > THR);
    gv = fired ? RSTV : n;
    check(req, int'(mem_v), int'(spike), gv, int'(fired));
  endtask

  task automatic step1(input int cur, input string req);
    int n;
    bit f;
    @(negedge clk);
    step_en1 = 1'b1;
    i_cur1 = 16'(cur);
    @(posedge clk);
    #1;
    step_en1 = 1'b0;
    n = g_next(gv1, cur, REST1);
    f = (n > THR1);
    gv1 = f ? RSTV : n;
    check(req, int'(mem_v1), int'(spike1), gv1, int'(f));
  endtask

  task automatic idle0(input int cur, input string req);
    @(negedge clk);
    step_en = 1'b0;
    i_cur = 16'(cur);
    @(posedge clk);
    #1;
    check(req, int'(mem_v), int'(spike), gv, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step_en = 1'b0;
    step_en1 = 1'b0;
    @(posedge clk);
    #1;
    gv = RSTV;
    gv1 = RSTV;
    check("R1 in reset", int'(mem_v), int'(spike), RSTV, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after release", int'(mem_v), int'(spike), RSTV, 0);
    check("R1 second instance", int'(mem_v1), int'(spike1), RSTV, 0);
  endtask

  task automatic t_idle();
    bit f;
    step0(3000, "R3 pre-idle step", f);
    idle0(32767, "R2 idle with large current");
    idle0(-32768, "R2 idle with negative current");
    step0(-800, "R3 step after idle", f);
    idle0(0, "R2 idle after step");
  endtask

  // R3 R7 R8: constant drive produces periodic spikes
  task automatic t_const_drive();
    bit f;
    int fires = 0;
    for (int k = 0; k < 80; k++) begin
      step0(5120, "R3 R7 constant drive", f);
      if (f) begin
        fires++;
        idle0(5120, "R8 pulse ends after one cycle");
      end
    end
    check("R7 constant drive fires", fires > 0 ? 1 : 0, 0, 1, 0);
  endtask

  task automatic t_threshold_edge();
    bit f;
    int need;
    t_reset();
    while (gv < -13600) step0(5120, "R3 approach threshold", f);
    need = 16 * (THR - gv) + (gv - REST);
    step0(need, "R7 equal to threshold no spike", f);
    check("R7 stored threshold value", int'(mem_v), int'(spike), THR, 0);
    step0(16 + (THR - REST), "R7 one LSB above fires", f);
    check("R8 reset load with spike", int'(mem_v), int'(spike), RSTV, 1);
    idle0(0, "R8 single cycle pulse");
  endtask

  task automatic t_sat_low();
    bit f;
    t_reset();
    for (int k = 0; k < 40; k++) step0(-32768, "R6 drive to lower rail", f);
    check("R6 lower rail", int'(mem_v), int'(spike), -32768, 0);
    step0(-32768, "R6 stays on lower rail", f);
    step0(32767, "R4 guard width from lower rail", f);
    check("R4 exact wide sum", int'(mem_v), 0, -29713, 0);
  endtask

  task automatic t_sat_high();
    for (int k = 0; k < 60; k++) step1(32767, "R5 drive to upper rail");
    check("R5 upper rail", int'(mem_v1), int'(spike1), 32767, 0);
    step1(32767, "R5 stays on upper rail");
    step1(-32768, "R4 guard width from upper rail");
  endtask

  task automatic t_mixed();
    bit f;
    int pat[8] = '{0, -1000, 300, 7000, -7, 16, -16, 12345};
    t_reset();
    foreach (pat[k]) begin
      step0(pat[k], "R3 mixed currents", f);
      if (k % 3 == 2) idle0(pat[k], "R2 idle inside mix");
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_idle();
    t_const_drive();
    t_threshold_edge();
    t_sat_low();
    t_sat_high();
    t_mixed();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule